// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block sits between an internal single-word request port and an external asynchronous 64K x 16 static RAM. Each accepted request is turned into a timed sequence of active-low strobes: chip select, write strobe, output enable and one enable per byte lane. The block drives the address and the write data, and gives a separate output-enable so a pad ring can build the bidirectional data bus. It reads the returned data on the input half of that bus.

The memory has no clock. Its access time is met by holding the strobes for a parameter number of clock cycles, two by default at 100 MHz. Read data is captured on the clock edge that ends the last wait cycle. A request carries a two-bit byte mask. On a write, only the selected lanes are stored. On a read, lanes that are not selected come back as zero. Between a write and a following read, and between a read and a following write, the block inserts one quiet cycle with the bus released. Only one request is in flight at a time. New work is taken only while the controller is idle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While idle, including directly after reset, the chip select, write strobe, output enable and both lane enables are all high, the bus output-enable is low, and `req_ready_o` is high. `req_ready_o` is low in every other cycle. A request offered while `req_ready_o` is low is ignored.
- R2: A write holds chip select and write strobe low for exactly WAIT_CYCLES cycles, starting in the cycle after acceptance (or after the turnaround of R6). Output enable stays high throughout. The address and write data are driven and the bus output-enable is high. Mask bit 0 drives the lower-byte enable `mem_be_no[0]` (data bits 7:0) low. Mask bit 1 drives the upper-byte enable `mem_be_no[1]` (data bits 15:8) low.
- R3: After the write strobe rises, one further cycle follows. In that cycle all strobes are high, while the address, the write data and the bus output-enable remain unchanged. The block then returns to idle.
- R4: A read holds chip select and output enable low, with the write strobe high, for exactly WAIT_CYCLES cycles. The bus output-enable stays low, and the lane enables follow the mask as in R2.
- R5: Read data is sampled on the edge that ends the last wait cycle. `rsp_valid_o` is high for exactly the one following cycle, and `rsp_rdata_o` carries the sampled data with every lane whose mask bit is 0 forced to zero. No response is given for writes.
- R6: If an accepted request has the other direction than the previously accepted request, one cycle with all strobes high and the bus released comes before its access. The first request after reset and same-direction requests get no such cycle.
- R7: The bus output-enable is high only in the access and hold cycles of a write, and never while output enable is low.
- R8: The address stays constant from the first access cycle through the last access or hold cycle of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (16) | Word address |
| req_wdata_i | input | DATA_W (16) | Write data |
| req_mask_i | input | LANES (2) | Byte-lane select, bit 0 = low byte |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | DATA_W (16) | Read data, unselected lanes zero |
| mem_addr_o | output | ADDR_W (16) | Memory address |
| mem_ce_no | output | 1 | Chip select, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_be_no | output | LANES (2) | Lane enables, active low, bit 0 = low byte |
| mem_dq_o | output | DATA_W (16) | Data to the bus |
| mem_dq_i | input | DATA_W (16) | Data from the bus |
| mem_dq_oe_o | output | 1 | Drive the bus when high |

## Verification
The assertions assume that WAIT_CYCLES is at least 1. They also assume that `mem_dq_i` is only meaningful on the edge that ends a read, because every request field is registered at acceptance. The bench memory model therefore drives a fixed junk pattern on lanes that are not enabled and on every cycle that is not a read. This exposes any lane whose data should have been masked. While the controller is busy, the stimulus offers junk requests to prove they are ignored. It waits for an idle cycle before offering real work, and it mixes direction changes, partial masks and the edge addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TURN   = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int WAIT_CYCLES = 2,
  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     accept_i,
  input  logic     turn_i,
  input  logic     op_write_i,
  output ctrl_st_e state_o,
  output logic     last_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_CYCLES - 1);

  ctrl_st_e   state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_i) begin
          state_q <= turn_i ? ST_TURN : ST_ACCESS;
          cnt_q   <= '0;
        end
        ST_TURN: state_q <= ST_ACCESS;
        ST_ACCESS: begin
          if (cnt_q == LAST_CNT) begin
            state_q <= op_write_i ? ST_HOLD : ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign last_o  = (state_q == ST_ACCESS) && (cnt_q == LAST_CNT);

  // R2/R4: the wait counter never runs past its last value
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);
endmodule

// File: rtl/sram_ctrl_lanes.sv
module sram_ctrl_lanes #(
  parameter int LANES = 2,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              capture_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [LANES-1:0]  be_no,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_valid_o <= 1'b0;
    else         rsp_valid_o <= capture_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be_no[g] = !(active_i && mask_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        rdata_o[g*8 +: 8] <= '0;
      else if (capture_i) rdata_o[g*8 +: 8] <= mask_i[g] ? dq_i[g*8 +: 8] : 8'h00;
    end

    // R5: an unselected lane reads as zero
    p_lane_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !mask_i[g]) |-> (rdata_o[g*8 +: 8] == 8'h00));
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int WAIT_CYCLES = 2,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_mask_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  ctrl_st_e          state;
  logic              last;
  logic              accept, turn, in_access;
  logic              have_prev_q, op_write_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [LANES-1:0]  op_mask_q;

  assign req_ready_o = (state == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign turn        = have_prev_q && (op_write_q != req_write_i);
  assign in_access   = (state == ST_ACCESS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev_q <= 1'b0;
      op_write_q  <= 1'b0;
      op_addr_q   <= '0;
      op_wdata_q  <= '0;
      op_mask_q   <= '0;
    end else if (accept) begin
      have_prev_q <= 1'b1;
      op_write_q  <= req_write_i;
      op_addr_q   <= req_addr_i;
      op_wdata_q  <= req_wdata_i;
      op_mask_q   <= req_mask_i;
    end
  end

  sram_ctrl_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .turn_i     (turn),
    .op_write_i (op_write_q),
    .state_o    (state),
    .last_o     (last)
  );

  sram_ctrl_lanes #(.LANES(LANES)) u_lanes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (in_access),
    .capture_i   (last && !op_write_q),
    .mask_i      (op_mask_q),
    .dq_i        (mem_dq_i),
    .be_no       (mem_be_no),
    .rsp_valid_o (rsp_valid_o),
    .rdata_o     (rsp_rdata_o)
  );

  // strobes decoded straight from state flops
  assign mem_addr_o  = op_addr_q;
  assign mem_dq_o    = op_wdata_q;
  assign mem_ce_no   = !in_access;
  assign mem_we_no   = !(in_access && op_write_q);
  assign mem_oe_no   = !(in_access && !op_write_q);
  assign mem_dq_oe_o = op_write_q && (in_access || state == ST_HOLD);

  // checker state: length of each chip-select pulse
  logic [7:0] ce_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ce_run_q <= '0;
    else if (!mem_ce_no) ce_run_q <= (ce_run_q == 8'hFF) ? ce_run_q : ce_run_q + 1'b1;
    else                 ce_run_q <= '0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_ce_no && mem_we_no && mem_oe_no && (&mem_be_no) && !mem_dq_oe_o));

  p_write_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no && mem_dq_oe_o));

  // R2 and R4: every access pulse lasts WAIT_CYCLES
  p_pulse_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> (ce_run_q == 8'(WAIT_CYCLES)));

  p_we_rise_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && $stable(mem_addr_o) && $stable(mem_dq_o)));

  p_read_quiet_bus_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && mem_we_no));

  p_rsp_after_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(!mem_oe_no) && mem_oe_no));

  p_oe_after_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_no) |-> !$past(mem_dq_oe_o));

  p_bus_vs_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_addr_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));
endmodule

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 2;
  localparam int N_RAND     = 160;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    bit          write;
    logic [15:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
  } req_t;

  // kind: 0 idle, 1 turn, 2 write access, 3 write hold, 4 read access, 5 response
  typedef struct {
    int          kind;
    logic [5:0]  strobes;   // {ce, we, oe, be[1:0], dq_oe}
    bit          ready;
    bit          rsp;
    logic [15:0] rdata;
    bit          chk_addr;
    logic [15:0] addr;
    bit          chk_wd;
    logic [15:0] wd;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_o, mem_dq_i;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] sram    [0:255];
  logic [15:0] ref_mem [0:255];
  req_t req_q[$];
  exp_t exp_q[$];
  bit   have_prev = 1'b0;
  bit   prev_write = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(16), .DATA_W(16), .WAIT_CYCLES(W)) u_sram_lane_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_mask_i(req_mask),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_ce_no(mem_ce_n), .mem_we_no(mem_we_n),
    .mem_oe_no(mem_oe_n), .mem_be_no(mem_be_n), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe_o(mem_dq_oe)
  );

  // pin-level memory model; disabled lanes return a junk pattern
  always @* begin
    mem_dq_i = 16'h5A5A;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
      if (!mem_be_n[0]) mem_dq_i[7:0]  = sram[mem_addr[7:0]][7:0];
      if (!mem_be_n[1]) mem_dq_i[15:8] = sram[mem_addr[7:0]][15:8];
    end
  end

  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n) begin
      if (!mem_be_n[0]) sram[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_be_n[1]) sram[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string kind_tag(input int k);
    case (k)
      1:       return "R6";
      2:       return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic exp_t quiet(input int k, input bit rdy);
    exp_t e;
    e.kind = k; e.strobes = 6'b111110; e.ready = rdy; e.rsp = 1'b0;
    e.rdata = '0; e.chk_addr = 1'b0; e.addr = '0; e.chk_wd = 1'b0; e.wd = '0;
    return e;
  endfunction

  task automatic push_req(input req_t r);
    exp_t e;
    logic [15:0] rd;
    if (have_prev && prev_write != r.write) exp_q.push_back(quiet(1, 1'b0));
    for (int i = 0; i < W; i++) begin
      e = quiet(r.write ? 2 : 4, 1'b0);
      e.strobes  = r.write ? {3'b001, ~r.mask, 1'b1} : {3'b010, ~r.mask, 1'b0};
      e.chk_addr = 1'b1; e.addr = r.addr;
      e.chk_wd   = r.write; e.wd = r.data;
      exp_q.push_back(e);
    end
    if (r.write) begin
      e = quiet(3, 1'b0);
      e.strobes  = 6'b111111;
      e.chk_addr = 1'b1; e.addr = r.addr; e.chk_wd = 1'b1; e.wd = r.data;
      exp_q.push_back(e);
      if (r.mask[0]) ref_mem[r.addr[7:0]][7:0]  = r.data[7:0];
      if (r.mask[1]) ref_mem[r.addr[7:0]][15:8] = r.data[15:8];
    end else begin
      rd = ref_mem[r.addr[7:0]];
      if (!r.mask[0]) rd[7:0]  = 8'h00;
      if (!r.mask[1]) rd[15:8] = 8'h00;
      e = quiet(5, 1'b1);
      e.rsp = 1'b1; e.rdata = rd;
      exp_q.push_back(e);
    end
    have_prev  = 1'b1;
    prev_write = r.write;
  endtask

  task automatic add(input bit wr, input logic [15:0] a, input logic [15:0] d,
                     input logic [1:0] m);
    req_t r;
    r.write = wr; r.addr = a; r.data = d; r.mask = m;
    req_q.push_back(r);
  endtask

  task automatic compare(input exp_t e);
    string t;
    t = kind_tag(e.kind);
    chk(t, "ce/we/oe/be", {26'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n},
        {26'd0, e.strobes[5:1]});
    chk("R7", "dq_oe", {31'd0, mem_dq_oe}, {31'd0, e.strobes[0]});
    chk("R1", "ready", {31'd0, req_ready}, {31'd0, e.ready});
    chk("R5", "rsp_valid", {31'd0, rsp_valid}, {31'd0, e.rsp});
    if (e.rsp)      chk("R5", "rdata", {16'd0, rsp_rdata}, {16'd0, e.rdata});
    if (e.chk_addr) chk("R8", "addr", {16'd0, mem_addr}, {16'd0, e.addr});
    if (e.chk_wd)   chk(t, "wdata", {16'd0, mem_dq_o}, {16'd0, e.wd});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i]    = 16'(i * 16'h0101) ^ 16'h00C3;
      ref_mem[i] = 16'(i * 16'h0101) ^ 16'h00C3;
    end
  end

  initial begin : main
    exp_t rec;
    req_t r;
    bool_loop: begin end
    // scripted corner cases
    add(1'b1, 16'h0000, 16'hBEEF, 2'b11);  // first request: no turnaround (R6)
    add(1'b0, 16'h0000, 16'h0000, 2'b11);  // R6 turn, R4 read
    add(1'b0, 16'h0000, 16'h0000, 2'b01);  // R5 upper lane zero
    add(1'b0, 16'h0000, 16'h0000, 2'b10);  // R5 lower lane zero
    add(1'b1, 16'hFFFF, 16'h1234, 2'b01);  // R2 lower lane only
    add(1'b1, 16'hFFFF, 16'hAB00, 2'b10);  // back-to-back writes, upper lane
    add(1'b0, 16'hFFFF, 16'h0000, 2'b11);  // expects AB34
    add(1'b1, 16'h0042, 16'h7777, 2'b00);  // no lane enabled: nothing stored
    add(1'b0, 16'h0042, 16'h0000, 2'b11);
    add(1'b0, 16'h0042, 16'h0000, 2'b00);  // R5 all zero
    for (int i = 0; i < N_RAND; i++)
      add(1'($urandom_range(1)), 16'($urandom), 16'($urandom), 2'($urandom_range(3)));

    repeat (3) @(negedge clk);
    rec = quiet(0, 1'b1);
    compare(rec);  // R1 reset state
    rst_n = 1'b1;

    for (int cyc = 0; cyc < WATCHDOG + 10; cyc++) begin
      @(negedge clk);
      rec = (exp_q.size() > 0) ? exp_q.pop_front() : quiet(0, 1'b1);
      compare(rec);
      if (rec.ready && req_q.size() > 0 && $urandom_range(3) != 0) begin
        r = req_q.pop_front();
        req_valid = 1'b1; req_write = r.write; req_addr = r.addr;
        req_wdata = r.data; req_mask = r.mask;
        push_req(r);
      end else if (!rec.ready && $urandom_range(1) == 1) begin
        // R1: junk offered while busy must be ignored
        req_valid = 1'b1; req_write = 1'($urandom_range(1));
        req_addr = 16'($urandom); req_wdata = 16'($urandom);
        req_mask = 2'($urandom_range(3));
      end else begin
        req_valid = 1'b0;
      end
      if (!req_valid && req_q.size() == 0 && exp_q.size() == 0) break;
    end
    repeat (2) begin
      @(negedge clk);
      compare(quiet(0, 1'b1));
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule